// File: doc/BRIEF.md
# Single-Port Colour Palette Memory with Write Collision

This block stores the colour table used by a tile-and-sprite display. It holds 32 entries of 6 bits each. The entries form two banks of 16: the lower bank serves the background layer, and the upper bank serves sprites. In every pixel clock the display pipeline presents a 4-bit pixel index and a bank-select bit. One clock later the block returns the 6-bit colour for that index. Entry 0 of the background bank doubles as the backdrop colour.

The memory has a single port. An access-slot scheduler writes new colours through that same port, so a write takes over the read path for its clock. In a visible clock that carries a write, the output colour is the data being written, not the looked-up entry. These are the stray dots seen when the palette is changed during the active picture. Outside the visible region the output is held at the blank level, so a write there leaves no mark. A stored write shows from the next read of that entry onward, which is what makes palette splits between scanlines possible.

Top module: `palette_ram`

## Requirements
- R1: After reset, `color` is 0 and every one of the 32 entries reads back as 0.
- R2: In a visible clock without a write, `color` one clock later equals the stored entry at address {`bank_sel`, `pix_idx`}.
- R3: In a visible clock with `wr_en` high, `color` one clock later equals `wr_data` exactly, whatever the pixel index and bank.
- R4: In any clock with `visible` low, `color` one clock later is 0, even when a write happens in that clock.
- R5: A write is stored whether or not `visible` is high in that clock.
- R6: A read of an entry in the clock right after it was written returns the new value.
- R7: The read address puts `bank_sel` in bit 4 and `pix_idx` in bits 3:0. `bank_sel` = 1 selects entries 16 to 31 (sprite bank), and `bank_sel` = 0 selects entries 0 to 15 (background bank, entry 0 being the backdrop).
- R8: A write to one entry leaves all other entries unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset; clears all entries |
| visible | input | 1 | High inside the visible picture region |
| bank_sel | input | 1 | Palette bank for this pixel (0 background, 1 sprite) |
| pix_idx | input | 4 | Colour index within the bank |
| wr_en | input | 1 | Write strobe from the access-slot scheduler |
| wr_addr | input | 5 | Entry to write (0 to 31) |
| wr_data | input | 6 | Colour to store, 2 bits each of R, G, B |
| color | output | 6 | Registered colour for the pixel, one clock latency |

## Verification
The display read and the scheduler write can fall in the same pixel clock. That clock is where the collision shows. The bench provokes it with writes whose address differs from the read address, and with writes whose address matches it. It does this both inside and outside the visible region. It judges each case against a bench model: the output must equal the write data in visible collision clocks and 0 in blank ones. Follow-up reads then confirm that the write still reached storage and disturbed no other entry.

// File: rtl/palette_ram.sv
module palette_ram #(
  parameter int IDX_W = 4,
  parameter int COL_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               visible,
  input  logic               bank_sel,
  input  logic [IDX_W-1:0]   pix_idx,
  input  logic               wr_en,
  input  logic [IDX_W:0]     wr_addr,
  input  logic [COL_W-1:0]   wr_data,
  output logic [COL_W-1:0]   color
);

  localparam int DEPTH = 2 * (1 << IDX_W);

  logic [COL_W-1:0] mem [DEPTH];
  logic [IDX_W:0]   rd_addr;

  assign rd_addr = {bank_sel, pix_idx};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        color <= '0;
    else if (!visible) color <= '0;
    else if (wr_en)    color <= wr_data;
    else               color <= mem[rd_addr];
  end

  assert_reset_blank_R1: assert property (@(posedge clk)
    !rst_n |=> color == '0);

  assert_collision_shows_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && visible |=> color == $past(wr_data));

  assert_blank_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !visible |=> color == '0);

  assert_next_read_new_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) && $past(rst_n) && !wr_en && visible && rd_addr == $past(wr_addr)
      |=> color == $past(wr_data, 2));

endmodule

// File: tb/palette_ram_bench.sv
`timescale 1ns/1ps
module palette_ram_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       visible = 0;
  logic       bank_sel = 0;
  logic [3:0] pix_idx = 0;
  logic       wr_en = 0;
  logic [4:0] wr_addr = 0;
  logic [5:0] wr_data = 0;
  logic [5:0] color;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [5:0] model [32];

  always #2.5 clk = ~clk;

  palette_ram u_palette_ram (
    .clk(clk), .rst_n(rst_n), .visible(visible), .bank_sel(bank_sel),
    .pix_idx(pix_idx), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .color(color)
  );

  function automatic logic [5:0] expect_color(logic v, logic s, logic [3:0] i,
                                              logic w, logic [5:0] d);
    if (!v) return 6'd0;
    if (w) return d;
    return model[{s, i}];
  endfunction

  task automatic check(string req, logic [5:0] exp);
    checks++;
    if (color !== exp) begin
      errors++;
      $display("FAIL %s color=%0h expected=%0h", req, color, exp);
    end
  endtask

  task automatic step(logic v, logic s, logic [3:0] i, logic w,
                      logic [4:0] a, logic [5:0] d, string req);
    logic [5:0] e;
    @(negedge clk);
    visible = v; bank_sel = s; pix_idx = i; wr_en = w; wr_addr = a; wr_data = d;
    e = expect_color(v, s, i, w, d);
    @(posedge clk);
    #1;
    check(req, e);
    if (w) model[a] = d;
  endtask

  task automatic read_all(string req);
    for (int k = 0; k < 32; k++) step(1, k[4], k[3:0], 0, 0, 0, req);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2014));
    for (int k = 0; k < 32; k++) model[k] = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset output", 6'd0);
    @(negedge clk);
    rst_n = 1;

    read_all("R1 entries clear");

    step(0, 0, 0, 1, 5'd5, 6'h2A, "R4 blank write");
    step(1, 0, 4'd5, 0, 0, 0, "R6 R5 read after blank write");
    step(1, 0, 4'd3, 1, 5'd9, 6'h15, "R3 collision other addr");
    step(1, 0, 4'd9, 0, 0, 0, "R6 read back");
    step(1, 1, 4'd2, 1, 5'd18, 6'h3F, "R3 collision same addr");
    step(0, 1, 4'd2, 0, 0, 0, "R4 blank read");
    step(1, 0, 0, 1, 5'd0, 6'h01, "R3 backdrop write");
    step(1, 1, 0, 1, 5'd16, 6'h30, "R3 sprite bank write");
    step(1, 0, 0, 0, 0, 0, "R7 background entry 0");
    step(1, 1, 0, 0, 0, 0, "R7 sprite entry 16");
    step(1, 0, 4'd7, 1, 5'd7, 6'h00, "R3 collision zero data");
    read_all("R8 other entries intact");

    for (int n = 0; n < 3000; n++) begin
      logic v, s, w;
      logic [3:0] i;
      logic [4:0] a;
      logic [5:0] d;
      v = ($urandom % 4) != 0;
      s = $urandom;
      i = $urandom;
      w = ($urandom % 3) == 0;
      a = ($urandom % 2) ? {s, i} : 5'($urandom);
      d = $urandom;
      if (!v)      step(v, s, i, w, a, d, "R4 random blank");
      else if (w)  step(v, s, i, w, a, d, "R3 random collision");
      else         step(v, s, i, w, a, d, "R2 random read");
    end

    read_all("R8 R5 final contents");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule